// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Timer

This block turns a digital low-supply flag, a watchdog input and a timebase into processor resets. While the supply flag is raised, reset asserts at once. After the flag drops, reset stays asserted for a fixed number of timebase ticks. A watchdog watches the processor's activity line. If no transition arrives within the watchdog period, the block latches an active-low fault flag and issues a reset pulse of the same stretched length.

The timebase is either an external tick strobe, counted one tick per strobe, or an internal tick derived by dividing the system clock. The watchdog period that follows a reset is longer than the normal period, which gives boot code time before it must start toggling the line. The external comparator and the pad logic resolve the watchdog input into a level and a floating indication. While the input floats, the watchdog is switched off.

Top module: `supervisor_wdt`

## Requirements
- R1: `sys_rst` is 1 and `sys_rst_n` is 0 in the same cycle that `low_supply` is 1, with no clock edge needed. The two outputs are always complements.
- R2: After `low_supply` returns to 0, reset stays asserted for a whole number of timebase ticks: `EXT_RST` (default 2048) in external mode, `INT_RST` (default 200) in internal mode.
- R3: When `ext_clk_mode`=1, one tick is each cycle in which `ext_tick`=1. When `ext_clk_mode`=0, one tick occurs every `PRESCALE` clock cycles.
- R4: The first watchdog period after any reset ends is `EXT_WD_FIRST` (default 4096) ticks in external mode and `INT_WD_LONG` (default 1600) ticks in internal mode.
- R5: After a watchdog input transition, the period is `EXT_WD_NORM` (default 1024) ticks in external mode. In internal mode it is `INT_WD_SHORT` (default 100) when `short_wd`=1 and `INT_WD_LONG` when `short_wd`=0.
- R6: Any change of the synchronized level restarts the period, and so does each edge of a pulse lasting 2 clocks or more. The level is seen 2 clocks after it changes, so an edge takes effect on the 3rd rising clock.
- R7: On timeout, `wd_fault_n` goes to 0 and a reset pulse of the R2 length starts. `wd_fault_n` stays 0 through that pulse until a transition on the watchdog input is seen, which sets it back to 1.
- R8: With a static watchdog input, timeouts repeat. Every period that follows a watchdog reset uses the R4 length.
- R9: `wdi_float`=1 means the input is floating. After 2 clocks of synchronization it stops all timeouts and forces `wd_fault_n` to 1.
- R10: While `low_supply`=1, `wd_fault_n` is 1 from the next clock on, and no watchdog period runs.
- R11: While `rst_n`=0, `sys_rst`=1 and `wd_fault_n`=1. After `rst_n` is released, reset stretches exactly as it does after the supply flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| low_supply | input | 1 | 1 while the supply is below threshold (synchronous) |
| wdi_level | input | 1 | Watchdog input level, 1 = high (asynchronous) |
| wdi_float | input | 1 | 1 = watchdog input floating (asynchronous) |
| ext_tick | input | 1 | External timebase strobe, one tick per high cycle |
| ext_clk_mode | input | 1 | 1 = count `ext_tick`, 0 = internal prescaled tick |
| short_wd | input | 1 | Internal mode only: 1 = short normal period |
| sys_rst | output | 1 | Active-high processor reset |
| sys_rst_n | output | 1 | Active-low processor reset |
| wd_fault_n | output | 1 | Active-low latched watchdog fault |

## Verification
The hardest state to reach is a normal-length period: it runs only after a reset has ended and a watchdog edge has arrived, and its end can only be seen through the fault flag. The stimulus first lets the input sit still through two full first-period timeouts. It then toggles the line at the sample where reset drops and counts fault-high samples until the next timeout. A two-clock pulse is timed from its trailing edge, which shows that both edges restart the count. Each timebase configuration is swept with small parameters, and the expected lengths are computed as tick counts times the tick spacing.

// File: rtl/supervisor_wdt.sv
`timescale 1ns/1ps
module supervisor_wdt #(
  parameter int PRESCALE     = 50000,
  parameter int EXT_RST      = 2048,
  parameter int EXT_WD_NORM  = 1024,
  parameter int EXT_WD_FIRST = 4096,
  parameter int INT_RST      = 200,
  parameter int INT_WD_LONG  = 1600,
  parameter int INT_WD_SHORT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_supply,
  input  logic wdi_level,
  input  logic wdi_float,
  input  logic ext_tick,
  input  logic ext_clk_mode,
  input  logic short_wd,
  output logic sys_rst,
  output logic sys_rst_n,
  output logic wd_fault_n
);
  localparam int M_EXT  = EXT_WD_FIRST > EXT_RST ? EXT_WD_FIRST : EXT_RST;
  localparam int M_INT  = INT_WD_LONG > INT_RST ? INT_WD_LONG : INT_RST;
  localparam int MAXLEN = M_EXT > M_INT ? M_EXT : M_INT;
  localparam int CW = $clog2(MAXLEN + 1);
  localparam int PW = $clog2(PRESCALE + 1);

  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] rst_cnt, wd_cnt, rst_len, wd_period;
  logic [2:0]    lvl_q;
  logic [1:0]    flt_q;
  logic          rst_q, first_q, int_tick, tick, wdi_edge, wd_run, wd_timeout;

  assign int_tick = (pre_cnt == PW'(PRESCALE - 1));
  assign tick     = ext_clk_mode ? ext_tick : int_tick;
  assign rst_len  = ext_clk_mode ? CW'(EXT_RST) : CW'(INT_RST);
  assign wd_period = first_q      ? (ext_clk_mode ? CW'(EXT_WD_FIRST) : CW'(INT_WD_LONG))
                   : ext_clk_mode ? CW'(EXT_WD_NORM)
                   : short_wd     ? CW'(INT_WD_SHORT) : CW'(INT_WD_LONG);

  assign wdi_edge   = (lvl_q[2] ^ lvl_q[1]) & ~flt_q[1];
  assign wd_run     = ~rst_q & ~low_supply & ~flt_q[1];
  assign wd_timeout = wd_run & tick & ~wdi_edge & (wd_cnt >= wd_period - CW'(1));

  assign sys_rst   = rst_q | low_supply;
  assign sys_rst_n = ~sys_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pre_cnt <= '0;
    else if (int_tick) pre_cnt <= '0;
    else               pre_cnt <= pre_cnt + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q <= '0;
      flt_q <= '0;
    end else begin
      lvl_q <= {lvl_q[1:0], wdi_level};
      flt_q <= {flt_q[0], wdi_float};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q   <= 1'b1;
      rst_cnt <= '0;
    end else if (low_supply || wd_timeout) begin
      rst_q   <= 1'b1;
      rst_cnt <= '0;
    end else if (rst_q && tick) begin
      if (rst_cnt >= rst_len - CW'(1)) begin
        rst_q   <= 1'b0;
        rst_cnt <= '0;
      end else begin
        rst_cnt <= rst_cnt + CW'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_cnt  <= '0;
      first_q <= 1'b1;
    end else if (rst_q || low_supply) begin
      wd_cnt  <= '0;
      first_q <= 1'b1;
    end else if (flt_q[1]) begin
      wd_cnt  <= '0;
    end else if (wdi_edge) begin
      wd_cnt  <= '0;
      first_q <= 1'b0;
    end else if (tick) begin
      wd_cnt  <= wd_timeout ? '0 : wd_cnt + CW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       wd_fault_n <= 1'b1;
    else if (low_supply || flt_q[1])  wd_fault_n <= 1'b1;
    else if (wdi_edge)                wd_fault_n <= 1'b1;
    else if (wd_timeout)              wd_fault_n <= 1'b0;

  // R2
  held_after_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_supply) |-> sys_rst);
  // R7
  timeout_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout |=> (sys_rst && !wd_fault_n));
  // R7
  fault_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_fault_n && !low_supply && !flt_q[1] && !wdi_edge) |=> !wd_fault_n);
  // R9
  float_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q[1] |=> wd_fault_n);
  // R10
  supply_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |=> (wd_fault_n && sys_rst));
endmodule

// File: tb/supervisor_wdt_test.sv
`timescale 1ns/1ps
module supervisor_wdt_test;
  localparam int P = 3, ER = 8, EN = 4, EF = 16, IR = 5, IL = 12, IS = 3;

  logic clk = 0, rst_n = 0, low_supply = 0, wdi_level = 0, wdi_float = 0;
  logic ext_tick = 0, ext_clk_mode = 1, short_wd = 0;
  logic sys_rst, sys_rst_n, wd_fault_n;
  int gap = 1, checks = 0, fails = 0;

  supervisor_wdt #(.PRESCALE(P), .EXT_RST(ER), .EXT_WD_NORM(EN), .EXT_WD_FIRST(EF),
    .INT_RST(IR), .INT_WD_LONG(IL), .INT_WD_SHORT(IS)) uut (
    .clk(clk), .rst_n(rst_n), .low_supply(low_supply), .wdi_level(wdi_level),
    .wdi_float(wdi_float), .ext_tick(ext_tick), .ext_clk_mode(ext_clk_mode),
    .short_wd(short_wd), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .wd_fault_n(wd_fault_n));

  always #10 clk = ~clk;

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % gap;
      ext_tick = (ph == 0);
    end
  end

  task automatic chk(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic run_len(input bit use_fault, input logic val, input int start, output int n);
    n = start;
    for (int i = 0; i < 100000; i++) begin
      @(negedge clk);
      if ((use_fault ? wd_fault_n : sys_rst) !== val) break;
      n++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, f, nrm, r, u, bad;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 sys_rst", sys_rst, 1, 1);
    chk("R11 fault_n", wd_fault_n, 1, 1);
    rst_n = 1;
    run_len(0, 1, 1, n);
    chk("R11 stretch", n, ER, ER);
    low_supply = 1;
    for (int c = 0; c < 4; c++) begin
      ext_clk_mode = (c < 2);
      gap = (c == 1) ? 2 : 1;
      short_wd = (c == 3);
      u   = (c < 2) ? gap : P;
      f   = (c < 2) ? EF : IL;
      nrm = (c < 2) ? EN : (c == 3 ? IS : IL);
      r   = (c < 2) ? ER : IR;
      repeat (4) @(negedge clk);
      chk("R1 rst", sys_rst, 1, 1);
      chk("R1 rst_n", sys_rst_n, 0, 0);
      chk("R10 fault", wd_fault_n, 1, 1);
      low_supply = 0;
      run_len(0, 1, 1, n);
      chk("R2 R3 stretch", n, (r - 1) * u + 1, r * u);
      run_len(0, 0, 1, n);
      chk("R4 first period", n, f * u, f * u);
      chk("R7 fault low", wd_fault_n, 0, 0);
      run_len(0, 1, 1, n);
      chk("R7 pulse", n, r * u, r * u);
      run_len(0, 0, 1, n);
      chk("R8 repeat first", n, f * u, f * u);
      run_len(0, 1, 1, n);
      chk("R8 pulse", n, r * u, r * u);
      wdi_level = ~wdi_level;
      run_len(1, 0, 0, n);
      chk("R6 R7 clear delay", n, 2, 2);
      run_len(1, 1, 1, n);
      chk("R5 normal period", n, (nrm - 1) * u + 1, nrm * u);
      chk("R7 reset on timeout", sys_rst, 1, 1);
      run_len(0, 1, 1, n);
      chk("R7 pulse length", n, r * u, r * u);
      wdi_level = ~wdi_level;
      repeat (2) @(negedge clk);
      wdi_level = ~wdi_level;
      run_len(1, 0, 0, n);
      run_len(1, 1, 1, n);
      chk("R6 pulse restarts", n, (nrm - 1) * u + 3, nrm * u + 2);
      run_len(0, 1, 1, n);
      wdi_float = 1;
      repeat (3) @(negedge clk);
      chk("R9 fault high", wd_fault_n, 1, 1);
      bad = 0;
      for (int i = 0; i < (f + r + 2) * u; i++) begin
        @(negedge clk);
        if (sys_rst !== 0 || wd_fault_n !== 1) bad++;
      end
      chk("R9 disabled", bad, 0, 0);
      wdi_float = 0;
      run_len(0, 0, 1, n);
      chk("R7 fault before supply", wd_fault_n, 0, 0);
      low_supply = 1;
      #1;
      chk("R1 immediate", {30'd0, sys_rst, sys_rst_n}, 2, 2);
      @(negedge clk);
      chk("R10 fault forced", wd_fault_n, 1, 1);
      bad = 0;
      for (int i = 0; i < (f + 2) * u; i++) begin
        @(negedge clk);
        if (sys_rst !== 1 || wd_fault_n !== 1) bad++;
      end
      chk("R10 held", bad, 0, 0);
    end
    finish_run();
  end
endmodule